// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block starts a conversion on a 16-bit successive-approximation converter that has a parallel result bus, then collects the result. A one-cycle start request begins the sequence. The active-low read/convert strobe falls first. After a setup interval set in nanoseconds, the active-low chip-select strobe falls. Both strobes then rise together after a short, programmable low time. The length of each interval is computed from the clock period, always rounding up.

Once both strobes are high again, the sequencer follows the converter's BUSY line. BUSY is low while a conversion runs. The sequencer waits for BUSY to fall and then for it to rise, and that rising edge marks the result as ready. The sequencer then samples the bus and presents the signed word with a one-cycle valid pulse. An offset-binary copy of the word is presented alongside it. If BUSY never falls, or never rises again, a timeout flag is set and the sequencer returns to idle.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, both strobes are high, and `seq_busy`, `result_valid` and `timeout` are all low.
- R2: A start request accepted in idle drives `adc_rc_n` low on the next clock edge. `adc_cs_n` falls exactly SETUP_CYC cycles later, where SETUP_CYC = ceil(SETUP_NS / CLK_NS). Chip select is never low while read/convert is high.
- R3: `adc_cs_n` stays low for exactly CS_CYC = ceil(CS_NS / CLK_NS) cycles. Both strobes then return high on the same edge.
- R4: The BUSY input passes through a two-flop synchronizer. After the synchronized BUSY has been seen low, the synchronized low-to-high edge moves the sequencer into a capture state. The bus is sampled on the following edge, and `result_valid` is high on the fourth clock edge after the first edge that samples BUSY high. `result` equals the bus value, read as two's complement: 0x7FFF is positive full scale minus one LSB, 0x0000 is zero, 0xFFFF is one LSB below zero, and 0x8000 is negative full scale.
- R5: `result_ob` equals `result` with bit 15 inverted. So 0x7FFF maps to 0xFFFF, 0x0000 to 0x8000, 0xFFFF to 0x7FFF, and 0x8000 to 0x0000.
- R6: A start request is ignored while `seq_busy` is high. No second strobe sequence follows, either during or after the current conversion.
- R7: `seq_busy` goes high on the edge that accepts a start request. It falls on the same edge on which `result_valid` rises, or on which a timeout is flagged.
- R8: If synchronized BUSY is still high BUSY_LOW_TMO cycles after the wait for BUSY low begins, the sequencer sets `timeout`, drops `seq_busy` and produces no valid pulse. `timeout` stays set until the next accepted start request, which clears it.
- R9: If synchronized BUSY does not rise within BUSY_HIGH_TMO cycles of the wait for BUSY high, `timeout` is set and the sequencer returns to idle.
- R10: `result_valid` is high for exactly one cycle per completed conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle conversion request |
| adc_busy | input | 1 | Converter BUSY line, asynchronous, low while converting |
| adc_data | input | DW | Converter parallel result bus |
| adc_rc_n | output | 1 | Read/convert strobe, low selects convert |
| adc_cs_n | output | 1 | Chip-select strobe, active low |
| result | output | DW | Captured two's-complement word |
| result_ob | output | DW | Captured word in offset binary |
| result_valid | output | 1 | One-cycle pulse when `result` updates |
| seq_busy | output | 1 | High from an accepted start until valid or timeout |
| timeout | output | 1 | Set when BUSY fails to toggle, cleared by the next start |

## Verification
The bench uses nanosecond settings that are not whole multiples of the clock period. A design that truncated the division would shorten the read/convert setup or the chip-select window by one cycle, and the bench counts those windows exactly. It injects start pulses while chip select is low and during a conversion; a design that accepted them would restart the strobes or emit a second strobe sequence after the valid pulse. It holds BUSY high, and in a separate run holds it low, to force both timeouts. A design that kept `seq_busy` high, raised a valid pulse, or missed the timeout would be seen there. The four full-scale and midscale codes are applied directly to check the sign-bit inversion, and the latency from the BUSY rise to the valid pulse is counted, which exposes a missing or extra synchronizer stage.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DW            = 16,
  parameter int CLK_NS        = 10,
  parameter int SETUP_NS      = 100,
  parameter int CS_NS         = 150,
  parameter int BUSY_LOW_TMO  = 64,
  parameter int BUSY_HIGH_TMO = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adc_busy,
  input  logic [DW-1:0] adc_data,
  output logic          adc_rc_n,
  output logic          adc_cs_n,
  output logic [DW-1:0] result,
  output logic [DW-1:0] result_ob,
  output logic          result_valid,
  output logic          seq_busy,
  output logic          timeout
);
  localparam int SETUP_CYC = ((SETUP_NS + CLK_NS - 1) / CLK_NS) < 1 ? 1 : (SETUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int CS_CYC    = ((CS_NS + CLK_NS - 1) / CLK_NS) < 1 ? 1 : (CS_NS + CLK_NS - 1) / CLK_NS;
  localparam int MAX_A     = SETUP_CYC > CS_CYC ? SETUP_CYC : CS_CYC;
  localparam int MAX_B     = BUSY_LOW_TMO > BUSY_HIGH_TMO ? BUSY_LOW_TMO : BUSY_HIGH_TMO;
  localparam int MAX_CNT   = MAX_A > MAX_B ? MAX_A : MAX_B;
  localparam int CW        = $clog2(MAX_CNT + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RC_SETUP, S_CS_ASSERT, S_RELEASE, S_WAIT_LOW, S_WAIT_HIGH, S_CAPTURE
  } state_t;

  state_t        st, nxt;
  logic [CW-1:0] cnt;
  logic          b_q0, b_q1, b_q2;
  logic          rise, tmo_hit;

  assign rise      = b_q1 & ~b_q2;
  assign result_ob = {~result[DW-1], result[DW-2:0]};
  assign seq_busy  = (st != S_IDLE);

  always_comb begin
    nxt     = st;
    tmo_hit = 1'b0;
    case (st)
      S_IDLE:      if (start) nxt = S_RC_SETUP;
      S_RC_SETUP:  if (cnt == CW'(SETUP_CYC - 1)) nxt = S_CS_ASSERT;
      S_CS_ASSERT: if (cnt == CW'(CS_CYC - 1)) nxt = S_RELEASE;
      S_RELEASE:   nxt = S_WAIT_LOW;
      S_WAIT_LOW:
        if (!b_q1) nxt = S_WAIT_HIGH;
        else if (cnt == CW'(BUSY_LOW_TMO - 1)) begin
          nxt     = S_IDLE;
          tmo_hit = 1'b1;
        end
      S_WAIT_HIGH:
        if (rise) nxt = S_CAPTURE;
        else if (cnt == CW'(BUSY_HIGH_TMO - 1)) begin
          nxt     = S_IDLE;
          tmo_hit = 1'b1;
        end
      S_CAPTURE:   nxt = S_IDLE;
      default:     nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q0 <= 1'b1;
      b_q1 <= 1'b1;
      b_q2 <= 1'b1;
    end else begin
      b_q0 <= adc_busy;
      b_q1 <= b_q0;
      b_q2 <= b_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      adc_rc_n     <= 1'b1;
      adc_cs_n     <= 1'b1;
      result       <= '0;
      result_valid <= 1'b0;
      timeout      <= 1'b0;
    end else begin
      st           <= nxt;
      cnt          <= (nxt != st) ? '0 : cnt + 1'b1;
      adc_rc_n     <= !(nxt == S_RC_SETUP || nxt == S_CS_ASSERT);
      adc_cs_n     <= !(nxt == S_CS_ASSERT);
      result_valid <= (st == S_CAPTURE);
      if (st == S_CAPTURE) result <= adc_data;
      if (tmo_hit) timeout <= 1'b1;
      else if (st == S_IDLE && start) timeout <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int DW       = 16,
  parameter int CLK_NS   = 10,
  parameter int SETUP_NS = 100,
  parameter int CS_NS    = 150
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_rc_n,
  input logic          adc_cs_n,
  input logic [DW-1:0] result,
  input logic          result_valid,
  input logic          seq_busy,
  input logic          timeout
);
  localparam int SETUP_CYC = ((SETUP_NS + CLK_NS - 1) / CLK_NS) < 1 ? 1 : (SETUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int CS_CYC    = ((CS_NS + CLK_NS - 1) / CLK_NS) < 1 ? 1 : (CS_NS + CLK_NS - 1) / CLK_NS;

  logic [15:0] rc_lo, cs_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_lo <= '0;
      cs_lo <= '0;
    end else begin
      rc_lo <= adc_rc_n ? '0 : (rc_lo == 16'hFFFF ? rc_lo : rc_lo + 1'b1);
      cs_lo <= adc_cs_n ? '0 : (cs_lo == 16'hFFFF ? cs_lo : cs_lo + 1'b1);
    end
  end

  p_cs_inside_rc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> !adc_rc_n);
  p_setup_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> rc_lo >= 16'(SETUP_CYC));
  p_cs_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> cs_lo < 16'(CS_CYC));
  p_joint_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> adc_rc_n);
  p_strobe_needs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rc_n |-> seq_busy);
  p_busy_ends_at_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> !seq_busy && $past(seq_busy));
  p_timeout_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> !seq_busy && !result_valid);
  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
endmodule

bind adc_conv_seq adc_conv_seq_chk #(
  .DW(DW), .CLK_NS(CLK_NS), .SETUP_NS(SETUP_NS), .CS_NS(CS_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_rc_n(adc_rc_n), .adc_cs_n(adc_cs_n),
  .result(result), .result_valid(result_valid), .seq_busy(seq_busy), .timeout(timeout)
);

// File: tb/adc_conv_seq_test.sv
module adc_conv_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SET_NS     = 95;
  localparam int CSW_NS     = 42;
  localparam int LOW_TMO    = 20;
  localparam int HIGH_TMO   = 300;

  logic        clk = 0, rst_n = 0, start = 0, adc_busy = 1;
  logic [15:0] adc_data = '0;
  logic        adc_rc_n, adc_cs_n, result_valid, seq_busy, timeout;
  logic [15:0] result, result_ob;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_conv_seq #(.DW(16), .CLK_NS(CLK_PERIOD), .SETUP_NS(SET_NS), .CS_NS(CSW_NS),
                 .BUSY_LOW_TMO(LOW_TMO), .BUSY_HIGH_TMO(HIGH_TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_busy(adc_busy), .adc_data(adc_data),
    .adc_rc_n(adc_rc_n), .adc_cs_n(adc_cs_n), .result(result), .result_ob(result_ob),
    .result_valid(result_valid), .seq_busy(seq_busy), .timeout(timeout));

  function automatic int ceil_cyc(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic logic [15:0] to_ob(input logic [15:0] v);
    return v ^ 16'h8000;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mode 0 normal, 1 BUSY never falls, 2 BUSY never rises
  task automatic run(input int mode, input logic [15:0] d, input int lowdly,
                     input int convlen, input bit inj);
    int n;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(!adc_rc_n && adc_cs_n, "R2 rc_n low after start", {adc_rc_n, adc_cs_n}, 2'b01);
    chk(seq_busy, "R7 busy after start", seq_busy, 1);
    chk(!timeout, "R8 timeout cleared by start", timeout, 0);
    n = 0;
    while (adc_cs_n && n < 1000) begin n++; @(negedge clk); end
    chk(n == ceil_cyc(SET_NS), "R2 setup cycles", n, ceil_cyc(SET_NS));
    n = 0;
    while (!adc_cs_n && n < 1000) begin
      if (adc_rc_n) chk(0, "R2 cs low with rc high", adc_rc_n, 0);
      start = inj && (n == 1);
      n++;
      @(negedge clk);
    end
    start = 0;
    chk(n == ceil_cyc(CSW_NS), "R3 cs low cycles", n, ceil_cyc(CSW_NS));
    chk(adc_rc_n && adc_cs_n, "R3 joint release", {adc_rc_n, adc_cs_n}, 2'b11);
    repeat (lowdly) @(negedge clk);
    if (mode == 1) begin
      repeat (LOW_TMO - 3) @(negedge clk);
      chk(!timeout && seq_busy, "R8 no early timeout", {timeout, seq_busy}, 2'b01);
      repeat (10) @(negedge clk);
      chk(timeout && !seq_busy && !result_valid, "R8 low timeout",
          {timeout, seq_busy, result_valid}, 3'b100);
      return;
    end
    adc_busy = 0;
    if (mode == 2) begin
      repeat (HIGH_TMO - 2) @(negedge clk);
      chk(!timeout && seq_busy, "R9 no early timeout", {timeout, seq_busy}, 2'b01);
      repeat (10) @(negedge clk);
      chk(timeout && !seq_busy && !result_valid, "R9 high timeout",
          {timeout, seq_busy, result_valid}, 3'b100);
      adc_busy = 1;
      repeat (6) @(negedge clk);
      chk(!result_valid && adc_rc_n, "R9 late BUSY rise ignored", result_valid, 0);
      return;
    end
    for (int i = 0; i < convlen; i++) begin
      start = inj && (i == 3);
      @(negedge clk);
    end
    start = 0;
    adc_data = d;
    adc_busy = 1;
    n = 0;
    while (!result_valid && n < 20) begin n++; @(negedge clk); end
    chk(n == 4, "R4 capture latency", n, 4);
    chk(result == d, "R4 captured word", result, d);
    chk(result_ob == to_ob(d), "R5 offset binary", result_ob, to_ob(d));
    chk(!seq_busy, "R7 busy drops with valid", seq_busy, 0);
    adc_data = ~d;
    @(negedge clk);
    chk(!result_valid && result == d, "R10 single valid pulse", result_valid, 0);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (!adc_rc_n || !adc_cs_n) n++;
      @(negedge clk);
    end
    chk(n == 0, "R6 no stray sequence", n, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(adc_rc_n && adc_cs_n && !seq_busy && !result_valid && !timeout, "R1 reset state",
        {adc_rc_n, adc_cs_n, seq_busy, result_valid, timeout}, 5'b11000);
    rst_n = 1;
    @(negedge clk);
    run(0, 16'h7FFF, 0, 20, 0);
    run(0, 16'h0000, 1, 25, 1);
    run(0, 16'hFFFF, 2, 30, 0);
    run(0, 16'h8000, 0, 40, 1);
    run(1, 16'h0, 1, 0, 0);
    run(0, 16'h1234, 0, 22, 0);
    run(2, 16'h0, 0, 0, 1);
    run(0, 16'hA5A5, 3, 35, 0);
    for (int k = 0; k < 12; k++)
      run(0, 16'($urandom), int'($urandom_range(0, 3)), int'($urandom_range(10, 200)),
          1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule